// File: doc/BRIEF.md
# Partial-Array Self-Refresh Sequencer

This block keeps the low-power extended mode settings of a four-bank mobile DDR memory and produces the bank and row addresses for refresh while the device sits in self refresh. A mode-register-set command aimed at the extended register loads three fields from the address bus. The first field selects the portion of the array that is kept alive. The second holds the output drive strength. The third holds a temperature-compensation code. The drive-strength and temperature-compensation fields are stored for readback only.

While self refresh is enabled, each refresh tick produces one refresh strobe. The strobe carries the current bank and row address. The sequencer then steps the row, and moves to the next bank when the row range is used up. Banks and rows outside the chosen portion are never visited, so their contents decay once the refresh period has passed. A write that breaks the loading rules is rejected, and a one-cycle flag reports it.

Top module: `pasr_refresh_seq`

## Requirements
- R1: Only a command with `mrs_cmd` high and `bank_sel` equal to binary 10 can change the stored fields. A command with any other `bank_sel` value changes nothing and raises no flag.
- R2: The region field is loaded from `addr[2:0]`. Its legal codes are 000, 001, 010, 101 and 110, and it resets to 000.
- R3: The drive field is loaded from `addr[6:5]`, with legal codes 00, 01 and 10, and it resets to 00. The temperature field is loaded from `addr[4:3]`, accepts any value, and resets to 00. A legal write shows on the outputs in the cycle after the command.
- R4: A write to the extended register is rejected in four cases: `banks_idle` is low, any of `addr[12:7]` is nonzero, the region code is reserved (011, 100 or 111), or the drive code is 11. A rejected write leaves all fields unchanged and drives `wr_illegal` high for exactly the one cycle after the command.
- R5: The stored fields keep their values until the next accepted write or until reset.
- R6: Each cycle with both `ref_tick` and `sr_en` high produces `ref_strobe` in the next cycle, together with the bank and row being refreshed. No strobe is produced otherwise.
- R7: The visited region depends on the region code. Code 000 covers banks 0 to 3 with all 8192 rows. Code 001 covers banks 0 and 1 with all rows. Code 010 covers bank 0 with all rows. Code 101 covers bank 0, rows 0 to 4095. Code 110 covers bank 0, rows 0 to 2047. The row increments first. The bank advances when the row wraps, and after the last bank the sequence returns to bank 0, row 0.
- R8: The region in use is taken from the region field only while `sr_en` is low. A write during self refresh does not change the sequence in progress. Each entry into self refresh starts at bank 0, row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_cmd | input | 1 | Mode-register-set command strobe |
| bank_sel | input | 2 | Bank address of the command, selects the register |
| addr | input | 13 | Address bus carrying the register value |
| banks_idle | input | 1 | All banks idle |
| sr_en | input | 1 | Self refresh active |
| ref_tick | input | 1 | Refresh interval tick |
| ref_bank | output | 2 | Bank of the current refresh |
| ref_row | output | 13 | Row of the current refresh |
| ref_strobe | output | 1 | One refresh issued this cycle |
| pasr_field | output | 3 | Stored region code |
| drive_field | output | 2 | Stored drive-strength code |
| temp_field | output | 2 | Stored temperature code |
| wr_illegal | output | 1 | One-cycle pulse for a rejected write |

## Verification
The hardest cases to reach are the wrap points of the larger regions and a region change made in the middle of self refresh. Reaching the wrap at the last bank of the full array takes 32768 ticks, so the bench keeps `ref_tick` high on every cycle and runs each region past its last address before it checks the return to bank 0, row 0. To check the frozen region, the bench writes a new region code partway through a run and confirms that the run keeps its old pattern. It then leaves and re-enters self refresh and confirms that the new region starts at zero.

// File: rtl/pasr_refresh_seq.sv
module pasr_refresh_seq #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs_cmd,
  input  logic [1:0]       bank_sel,
  input  logic [ROW_W-1:0] addr,
  input  logic             banks_idle,
  input  logic             sr_en,
  input  logic             ref_tick,
  output logic [1:0]       ref_bank,
  output logic [ROW_W-1:0] ref_row,
  output logic             ref_strobe,
  output logic [2:0]       pasr_field,
  output logic [1:0]       drive_field,
  output logic [1:0]       temp_field,
  output logic             wr_illegal
);
  localparam logic [1:0]       EXT_SEL  = 2'b10;
  localparam logic [ROW_W-1:0] ROW_ALL  = '1;
  localparam logic [ROW_W-1:0] ROW_HALF = ROW_ALL >> 1;
  localparam logic [ROW_W-1:0] ROW_QTR  = ROW_ALL >> 2;

  logic [2:0]       act_q;
  logic [1:0]       bank_q;
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_lim;
  logic [1:0]       bank_lim;

  wire ext_wr  = mrs_cmd && (bank_sel == EXT_SEL);
  wire pasr_ok = addr[2:0] inside {3'b000, 3'b001, 3'b010, 3'b101, 3'b110};
  wire ds_ok   = addr[6:5] != 2'b11;
  wire hi_ok   = addr[ROW_W-1:7] == '0;
  wire wr_ok   = ext_wr && banks_idle && pasr_ok && ds_ok && hi_ok;
  wire step    = sr_en && ref_tick;

  always_comb begin
    case (act_q)
      3'b000:  begin bank_lim = 2'd3; row_lim = ROW_ALL;  end
      3'b001:  begin bank_lim = 2'd1; row_lim = ROW_ALL;  end
      3'b101:  begin bank_lim = 2'd0; row_lim = ROW_HALF; end
      3'b110:  begin bank_lim = 2'd0; row_lim = ROW_QTR;  end
      default: begin bank_lim = 2'd0; row_lim = ROW_ALL;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pasr_field  <= '0;
      drive_field <= '0;
      temp_field  <= '0;
      wr_illegal  <= 1'b0;
    end else begin
      wr_illegal <= ext_wr && !wr_ok;
      if (wr_ok) begin
        pasr_field  <= addr[2:0];
        temp_field  <= addr[4:3];
        drive_field <= addr[6:5];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q      <= '0;
      bank_q     <= '0;
      row_q      <= '0;
      ref_strobe <= 1'b0;
      ref_bank   <= '0;
      ref_row    <= '0;
    end else begin
      ref_strobe <= step;
      if (!sr_en) begin
        act_q  <= pasr_field;
        bank_q <= '0;
        row_q  <= '0;
      end else if (step) begin
        ref_bank <= bank_q;
        ref_row  <= row_q;
        if (row_q == row_lim) begin
          row_q  <= '0;
          bank_q <= (bank_q == bank_lim) ? 2'd0 : bank_q + 2'd1;
        end else begin
          row_q <= row_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pasr_refresh_seq_chk.sv
module pasr_refresh_seq_chk #(
  parameter int ROW_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mrs_cmd,
  input logic [1:0]       bank_sel,
  input logic             sr_en,
  input logic             ref_tick,
  input logic [1:0]       ref_bank,
  input logic [ROW_W-1:0] ref_row,
  input logic             ref_strobe,
  input logic [2:0]       pasr_field,
  input logic [1:0]       drive_field,
  input logic [1:0]       temp_field,
  input logic             wr_illegal,
  input logic [2:0]       act_q
);
  // R6
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_strobe |-> $past(sr_en && ref_tick));
  // R4
  illegal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_illegal |-> $past(mrs_cmd && bank_sel == 2'b10));
  // R3
  drive_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_field != 2'b11);
  // R2
  pasr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pasr_field inside {3'b000, 3'b001, 3'b010, 3'b101, 3'b110});
  // R5
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mrs_cmd) |-> $stable({pasr_field, drive_field, temp_field}));
  // R7
  region_q16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_strobe && act_q == 3'b110) |-> (ref_bank == 2'd0 && ref_row[ROW_W-1 -: 2] == 2'b00));
  // R8
  entry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_strobe && $past(!sr_en, 2)) |-> (ref_bank == 2'd0 && ref_row == '0));
endmodule

bind pasr_refresh_seq pasr_refresh_seq_chk #(.ROW_W(ROW_W)) u_chk (.*);

// File: tb/test_pasr_refresh_seq.sv
module test_pasr_refresh_seq;
  logic        clk = 0, rst_n = 0, mrs_cmd = 0, banks_idle = 1, sr_en = 0, ref_tick = 0;
  logic [1:0]  bank_sel = 0;
  logic [12:0] addr = 0;
  logic [1:0]  ref_bank, drive_field, temp_field;
  logic [12:0] ref_row;
  logic [2:0]  pasr_field;
  logic        ref_strobe, wr_illegal;

  int total = 0, bad = 0;
  logic [14:0] expq[$];
  logic [1:0]  m_bank;
  logic [12:0] m_row;
  logic [2:0]  m_reg;

  always #2 clk = ~clk;

  pasr_refresh_seq i_pasr_refresh_seq (.*);

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && ref_strobe) begin
    if (expq.size() == 0) check("R6 unexpected strobe", 1, 0);
    else begin
      logic [14:0] e;
      e = expq.pop_front();
      check("R7 refresh address", {ref_bank, ref_row}, e);
    end
  end

  task automatic advance();
    int rows, banks;
    rows  = (m_reg == 3'b101) ? 4096 : (m_reg == 3'b110) ? 2048 : 8192;
    banks = (m_reg == 3'b000) ? 4 : (m_reg == 3'b001) ? 2 : 1;
    if (int'(m_row) + 1 == rows) begin
      m_row  = 0;
      m_bank = 2'((int'(m_bank) + 1) % banks);
    end else m_row = m_row + 1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      ref_tick = 1;
      expq.push_back({m_bank, m_row});
      advance();
      @(negedge clk);
    end
    ref_tick = 0;
    @(negedge clk);
    @(negedge clk);
    check("R6 queue drained", expq.size(), 0);
  endtask

  task automatic mrs(logic [1:0] ba, logic [12:0] a, logic idle, logic exp_bad);
    mrs_cmd = 1; bank_sel = ba; addr = a; banks_idle = idle;
    @(negedge clk);
    mrs_cmd = 0; banks_idle = 1;
    check("R4 illegal pulse", wr_illegal, exp_bad);
    @(negedge clk);
    check("R4 pulse one cycle", wr_illegal, 0);
  endtask

  task automatic fields(string tag, int p, int d, int t);
    check({tag, " region"}, pasr_field, p);
    check({tag, " drive"}, drive_field, d);
    check({tag, " temp"}, temp_field, t);
  endtask

  task automatic run_region(logic [2:0] p, int n);
    mrs(2'b10, {6'b0, 2'b00, 2'b00, p}, 1, 0);
    check("R2 region write", pasr_field, p);
    m_reg = p; m_bank = 0; m_row = 0;
    sr_en = 1;
    ticks(n);
    sr_en = 0;
    @(negedge clk);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    fields("R2 R3 reset", 0, 0, 0);
    check("R6 reset strobe", ref_strobe, 0);
    check("R4 reset flag", wr_illegal, 0);

    mrs(2'b10, {6'b0, 2'b01, 2'b11, 3'b110}, 1, 0);
    fields("R3 legal write", 6, 1, 3);
    mrs(2'b10, {6'b0, 2'b10, 2'b01, 3'b101}, 0, 1);
    fields("R4 busy banks", 6, 1, 3);
    mrs(2'b10, {6'b000100, 2'b10, 2'b01, 3'b101}, 1, 1);
    fields("R4 high bits", 6, 1, 3);
    mrs(2'b10, {6'b0, 2'b10, 2'b01, 3'b011}, 1, 1);
    fields("R4 reserved region", 6, 1, 3);
    mrs(2'b10, {6'b0, 2'b11, 2'b01, 3'b001}, 1, 1);
    fields("R4 reserved drive", 6, 1, 3);
    mrs(2'b00, {6'b0, 2'b10, 2'b01, 3'b001}, 1, 0);
    fields("R1 other register", 6, 1, 3);
    mrs(2'b01, {6'b0, 2'b00, 2'b00, 3'b000}, 1, 0);
    fields("R1 other register", 6, 1, 3);
    repeat (5) @(negedge clk);
    fields("R5 persist", 6, 1, 3);

    ref_tick = 1;
    repeat (3) @(negedge clk);
    check("R6 tick without self refresh", ref_strobe, 0);
    ref_tick = 0;
    sr_en = 1;
    repeat (3) @(negedge clk);
    check("R6 self refresh without tick", ref_strobe, 0);
    sr_en = 0;
    @(negedge clk);

    run_region(3'b110, 2048 + 5);
    run_region(3'b101, 4096 + 5);
    run_region(3'b010, 8192 + 3);

    mrs(2'b10, {6'b0, 2'b00, 2'b00, 3'b001}, 1, 0);
    m_reg = 3'b001; m_bank = 0; m_row = 0;
    sr_en = 1;
    ticks(100);
    mrs(2'b10, {6'b0, 2'b00, 2'b00, 3'b110}, 1, 0);
    check("R8 field updates in self refresh", pasr_field, 6);
    ticks(16384 - 100 + 5);
    sr_en = 0;
    @(negedge clk);
    m_reg = 3'b110; m_bank = 0; m_row = 0;
    sr_en = 1;
    ticks(2048 + 2);
    sr_en = 0;
    @(negedge clk);

    run_region(3'b000, 32768 + 4);
    finish_up();
  end
endmodule